// File: doc/BRIEF.md
# Burst Beat Address and Lane Generator

This block turns one burst request into a stream of beats. A request gives a start byte address, a length field, a size field and a burst kind. The length field is the beat count minus one. The size field selects 2^size bytes per beat. The kind selects one of three address patterns. A constant address suits a FIFO-like target. An incrementing address steps by the transfer size. A wrapping address folds back to the low end of an aligned window. For each beat the block outputs the byte address, a lane-enable mask with one bit per byte of the data bus, and a flag that marks the final beat. The consumer takes beats with a valid/ready handshake.

The block checks each request as it is accepted. A request that is illegal produces no beats. Instead, the block raises a one-cycle error pulse and is ready for the next request at once. The block handles only one burst at a time. It accepts a new request only after the final beat of the current burst has been taken. An upstream master places it between its command queue and its data-lane steering. It supplies the address and lane information that a write-data or read-data path needs on each beat.

Top module: `burst_beat_gen`

## Requirements
- R1: A legal request with length field L yields exactly L+1 beats. `beat_last` is high on the final beat and on no other beat. An illegal request yields no beat, and `req_err` stays low while beats are offered.
- R2: Kind code 0 (constant) presents the start address unchanged on every beat.
- R3: Kind code 1 (incrementing) presents the start address on the first beat. Each later beat presents the size-aligned start address plus the beat index times 2^size. For an unaligned start, the first beat enables only the lanes from the start byte up to the end of its size-aligned container.
- R4: Kind code 2 (wrapping) steps like kind 1 inside a window of 2^size × (L+1) bytes that is aligned to its own span. A step that reaches the top of the window returns to the window base.
- R5: `beat_strb` bit i is set for the 2^size lanes starting at lane (address mod bus bytes) of a size-aligned address. On a 32-bit bus, size 0 at address offset 1 gives 4'b0010, and size 2 gives 4'b1111.
- R6: A kind 2 request is flagged as an error in either of two cases: its start address has nonzero bits below 2^size, or its beat count is not 2, 4, 8 or 16.
- R7: A kind 0 or kind 2 request with a length field above 15 is flagged as an error.
- R8: A request whose 2^size exceeds the bus width in bytes is flagged as an error.
- R9: A kind 1 request is flagged as an error if its bytes, from the size-aligned start through the last beat, reach past a 4096-byte boundary. A burst that ends exactly at the boundary is legal.
- R10: Kind code 3 is reserved and is flagged as an error.
- R11: While `beat_valid` is high and `beat_ready` is low, the beat outputs hold and `beat_valid` stays high.
- R12: After reset, `req_ready` is high and `beat_valid` and `req_err` are low. `req_ready` is low while a burst is in progress and returns high in the cycle after the final beat is taken. `req_err` pulses for one cycle, in the cycle after an illegal request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | 8 | Beat count minus one |
| req_size | input | 3 | log2 of bytes per beat |
| req_kind | input | 2 | 0 constant, 1 incrementing, 2 wrapping, 3 reserved |
| beat_valid | output | 1 | Beat offered |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_addr | output | ADDR_W | Byte address of this beat |
| beat_strb | output | DATA_W/8 | Active byte lanes of this beat |
| beat_last | output | 1 | Final beat of the burst |
| req_err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The bound checker watches four properties on every cycle: beat outputs hold under backpressure, requests and beats never overlap, the block returns to idle after the final beat, and error pulses appear only after an accepted request with no beat offered. It also checks that constant bursts repeat their address, that incrementing bursts never leave their 4 KB page between beats, and that every offered beat has at least one active lane. The directed scenarios are the only way to show the exact address sequences and lane masks. This covers the wrap fold point, the partial first beat of an unaligned start, the exact beat count of a 256-beat burst, and which legality rule rejects each malformed request.

// File: rtl/burst_beat_pkg.sv
package burst_beat_pkg;

    localparam int PAGE_BITS = 12;
    localparam int LEN_W     = 8;
    localparam int SIZE_W    = 3;
    localparam int SHORT_MAX = 15;

    typedef enum logic [1:0] {
        KIND_FIXED = 2'd0,
        KIND_INCR  = 2'd1,
        KIND_WRAP  = 2'd2,
        KIND_RSVD  = 2'd3
    } burst_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gen_state_e;

    typedef struct packed {
        logic bad_kind;
        logic bad_size;
        logic bad_len;
        logic bad_wrap;
        logic bad_page;
    } req_fault_t;

    // length field giving 2, 4, 8 or 16 beats
    function automatic logic wrap_count_ok(input logic [LEN_W-1:0] len);
        return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
    endfunction

endpackage

// File: rtl/burst_req_check.sv
module burst_req_check
    import burst_beat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STRB_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    input  burst_kind_e       kind,
    output req_fault_t        fault
);
    localparam int MAX_SIZE = $clog2(STRB_W);
    localparam int OFF_W    = PAGE_BITS + LEN_W + 8;

    logic [ADDR_W-1:0]    size_mask;
    logic [PAGE_BITS-1:0] page_off;
    logic [OFF_W-1:0]     span_bytes;
    logic [OFF_W-1:0]     end_off;
    logic                 misaligned;

    always_comb begin
        size_mask  = (ADDR_W'(1) << size) - ADDR_W'(1);
        misaligned = |(addr & size_mask);
        page_off   = addr[PAGE_BITS-1:0] & ~size_mask[PAGE_BITS-1:0];
        span_bytes = (OFF_W'(len) + OFF_W'(1)) << size;
        end_off    = OFF_W'(page_off) + span_bytes;

        fault.bad_kind = (kind == KIND_RSVD);
        fault.bad_size = (int'(size) > MAX_SIZE);
        fault.bad_len  = (kind == KIND_FIXED || kind == KIND_WRAP) &&
                         (int'(len) > SHORT_MAX);
        fault.bad_wrap = (kind == KIND_WRAP) && (misaligned || !wrap_count_ok(len));
        fault.bad_page = (kind == KIND_INCR) &&
                         (end_off > (OFF_W'(1) << PAGE_BITS));
    end

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
    import burst_beat_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [SIZE_W-1:0] size,
    input  burst_kind_e       kind,
    input  logic [ADDR_W-1:0] wrap_mask,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] size_mask;
    logic [ADDR_W-1:0] stepped;

    always_comb begin
        size_mask = (ADDR_W'(1) << size) - ADDR_W'(1);
        stepped   = (cur_addr & ~size_mask) + (ADDR_W'(1) << size);
        unique case (kind)
            KIND_FIXED: next_addr = cur_addr;
            KIND_WRAP:  next_addr = (cur_addr & ~wrap_mask) | (stepped & wrap_mask);
            default:    next_addr = stepped;
        endcase
    end

endmodule

// File: rtl/burst_lane_mask.sv
module burst_lane_mask
    import burst_beat_pkg::*;
#(
    parameter int STRB_W = 4
) (
    input  logic [$clog2(STRB_W)-1:0] lane,
    input  logic [SIZE_W-1:0]         size,
    output logic [STRB_W-1:0]         strb
);
    localparam int LANE_W = $clog2(STRB_W);

    logic [LANE_W:0] nbytes;
    logic [LANE_W:0] cont_lo;
    logic [LANE_W:0] cont_hi;

    always_comb begin
        nbytes  = (LANE_W+1)'(1) << size;
        cont_lo = {1'b0, lane} & ~(nbytes - (LANE_W+1)'(1));
        cont_hi = cont_lo + nbytes;
    end

    for (genvar i = 0; i < STRB_W; i++) begin : g_lane
        assign strb[i] = ((LANE_W+1)'(i) >= {1'b0, lane}) && ((LANE_W+1)'(i) < cont_hi);
    end

endmodule

// File: rtl/burst_beat_gen.sv
module burst_beat_gen
    import burst_beat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic [SIZE_W-1:0]     req_size,
    input  logic [1:0]            req_kind,
    output logic                  beat_valid,
    input  logic                  beat_ready,
    output logic [ADDR_W-1:0]     beat_addr,
    output logic [DATA_W/8-1:0]   beat_strb,
    output logic                  beat_last,
    output logic                  req_err
);
    localparam int STRB_W = DATA_W / 8;
    localparam int LANE_W = $clog2(STRB_W);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        burst_kind_e       kind;
        logic [LEN_W-1:0]  remain;
        logic [ADDR_W-1:0] wrap_mask;
    } burst_ctx_t;

    gen_state_e  state;
    burst_ctx_t  ctx;
    logic        err_q;
    req_fault_t  fault;
    logic        illegal;
    logic        take_req;
    logic        take_beat;
    logic [ADDR_W-1:0] next_addr;
    burst_kind_e in_kind;

    assign in_kind   = burst_kind_e'(req_kind);
    assign req_ready = (state == ST_IDLE);
    assign take_req  = req_valid && req_ready;
    assign illegal   = |fault;
    assign beat_valid = (state == ST_RUN);
    assign take_beat = beat_valid && beat_ready;
    assign beat_addr = ctx.addr;
    assign beat_last = beat_valid && (ctx.remain == '0);
    assign req_err   = err_q;

    burst_req_check #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_check (
        .addr  (req_addr),
        .len   (req_len),
        .size  (req_size),
        .kind  (in_kind),
        .fault (fault)
    );

    burst_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur_addr  (ctx.addr),
        .size      (ctx.size),
        .kind      (ctx.kind),
        .wrap_mask (ctx.wrap_mask),
        .next_addr (next_addr)
    );

    burst_lane_mask #(.STRB_W(STRB_W)) u_lanes (
        .lane (ctx.addr[LANE_W-1:0]),
        .size (ctx.size),
        .strb (beat_strb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ctx   <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= take_req && illegal;
            unique case (state)
                ST_IDLE: begin
                    if (take_req && !illegal) begin
                        state         <= ST_RUN;
                        ctx.addr      <= req_addr;
                        ctx.size      <= req_size;
                        ctx.kind      <= in_kind;
                        ctx.remain    <= req_len;
                        ctx.wrap_mask <= ((ADDR_W'(req_len) + ADDR_W'(1)) << req_size)
                                         - ADDR_W'(1);
                    end
                end
                ST_RUN: begin
                    if (take_beat) begin
                        if (ctx.remain == '0) begin
                            state <= ST_IDLE;
                        end else begin
                            ctx.remain <= ctx.remain - 1'b1;
                            ctx.addr   <= next_addr;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/burst_beat_gen_chk.sv
module burst_beat_gen_chk
    import burst_beat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STRB_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_kind,
    input logic              beat_valid,
    input logic              beat_ready,
    input logic [ADDR_W-1:0] beat_addr,
    input logic [STRB_W-1:0] beat_strb,
    input logic              beat_last,
    input logic              req_err
);
    burst_kind_e kind_q;

    always_ff @(posedge clk) begin
        if (rst) kind_q <= KIND_FIXED;
        else if (req_valid && req_ready) kind_q <= burst_kind_e'(req_kind);
    end

    a_r11_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) &&
                                      $stable(beat_strb) && $stable(beat_last));

    a_r5_some_lane: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> $countones(beat_strb) > 0);

    a_r12_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && beat_valid));

    a_r12_idle_after_last: assert property (@(posedge clk) disable iff (rst)
        beat_valid && beat_ready && beat_last |=> req_ready && !beat_valid);

    a_r12_err_after_accept: assert property (@(posedge clk) disable iff (rst)
        req_err |-> $past(req_valid && req_ready));

    a_r1_err_no_beat: assert property (@(posedge clk) disable iff (rst)
        req_err |-> !beat_valid);

    a_r2_fixed_repeat: assert property (@(posedge clk) disable iff (rst)
        beat_valid && beat_ready && !beat_last && kind_q == KIND_FIXED
        |=> beat_addr == $past(beat_addr));

    a_r9_same_page: assert property (@(posedge clk) disable iff (rst)
        beat_valid && beat_ready && !beat_last && kind_q == KIND_INCR
        |=> beat_addr[ADDR_W-1:PAGE_BITS] == $past(beat_addr[ADDR_W-1:PAGE_BITS]));

endmodule

bind burst_beat_gen burst_beat_gen_chk #(.ADDR_W(ADDR_W), .STRB_W(DATA_W/8)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_kind   (req_kind),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_addr  (beat_addr),
    .beat_strb  (beat_strb),
    .beat_last  (beat_last),
    .req_err    (req_err)
);

// File: tb/burst_beat_gen_tb.sv
`timescale 1ns/1ps
module burst_beat_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [2:0]  req_size = '0;
    logic [1:0]  req_kind = '0;
    logic        beat_valid;
    logic        beat_ready = 1'b0;
    logic [31:0] beat_addr;
    logic [3:0]  beat_strb;
    logic        beat_last;
    logic        req_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 0;

    always #4 clk = ~clk;

    burst_beat_gen u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_size(req_size), .req_kind(req_kind),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_strb(beat_strb), .beat_last(beat_last),
        .req_err(req_err)
    );

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        end
        $finish;
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_addr(input logic [31:0] a, input int s, input int k,
                                           input int l, input int i);
        logic [31:0] nb, span, base;
        nb = 32'(1) << s;
        if (k == 0) return a;
        if (k == 1) return (i == 0) ? a : (a & ~(nb - 1)) + 32'(i) * nb;
        span = nb * 32'(l + 1);
        base = a & ~(span - 1);
        return base + (((a - base) + 32'(i) * nb) % span);
    endfunction

    function automatic logic [3:0] m_strb(input logic [31:0] a, input int s);
        int lane, nb, top;
        logic [3:0] m;
        lane = int'(a % 4);
        nb = 1 << s;
        top = (lane / nb) * nb + nb;
        for (int j = 0; j < 4; j++) m[j] = (j >= lane) && (j < top);
        return m;
    endfunction

    task automatic send(input logic [31:0] a, input int l, input int s, input int k,
                        output logic err_seen, output logic bv_seen);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr = a; req_len = 8'(l); req_size = 3'(s); req_kind = 2'(k);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        err_seen = req_err;
        bv_seen  = beat_valid;
    endtask

    task automatic run_ok(input string tag, input logic [31:0] a, input int l, input int s,
                          input int k, input bit bp);
        logic e, v, stalled;
        logic [31:0] sv_addr;
        logic [3:0]  sv_strb;
        logic        sv_last;
        int n, cyc;
        bit done;
        send(a, l, s, k, e, v);
        check(!e, {tag, " R1 no error on legal request"}, 32'(e), 0);
        check(v, {tag, " R12 beat offered after accept"}, 32'(v), 1);
        n = 0; cyc = 0; done = 0; stalled = 0;
        sv_addr = '0; sv_strb = '0; sv_last = 0;
        while (!done && cyc < 3000) begin
            beat_ready = bp ? (cyc % 3 != 0) : 1'b1;
            if (stalled) begin
                check(beat_valid && beat_addr == sv_addr && beat_strb == sv_strb &&
                      beat_last == sv_last, {tag, " R11 hold under stall"}, beat_addr, sv_addr);
            end
            if (beat_valid && beat_ready) begin
                check(beat_addr == m_addr(a, s, k, l, n), {tag, " R2/R3/R4 beat address"},
                      beat_addr, m_addr(a, s, k, l, n));
                check(beat_strb == m_strb(beat_addr, s), {tag, " R3/R5 lane mask"},
                      32'(beat_strb), 32'(m_strb(beat_addr, s)));
                check(beat_last == (n == l), {tag, " R1 last flag"}, 32'(beat_last), 32'(n == l));
                if (beat_last) done = 1;
                n++;
            end
            stalled = beat_valid && !beat_ready;
            sv_addr = beat_addr; sv_strb = beat_strb; sv_last = beat_last;
            cyc++;
            @(negedge clk);
        end
        beat_ready = 1'b0;
        check(n == l + 1, {tag, " R1 beat count"}, 32'(n), 32'(l + 1));
        check(req_ready && !beat_valid, {tag, " R12 idle after last"}, 32'(req_ready), 1);
    endtask

    task automatic run_bad(input string tag, input logic [31:0] a, input int l, input int s,
                           input int k);
        logic e, v;
        send(a, l, s, k, e, v);
        check(e, {tag, " error pulse"}, 32'(e), 1);
        check(!v, {tag, " R1 no beat on error"}, 32'(v), 0);
        @(negedge clk);
        check(!beat_valid && !req_err && req_ready, {tag, " R12 pulse ends, idle"},
              {29'd0, beat_valid, req_err, req_ready}, 32'd1);
    endtask

    task automatic t_reset();
        check(req_ready && !beat_valid && !req_err, "R12 reset state",
              {29'd0, req_ready, beat_valid, req_err}, 32'd4);
    endtask

    task automatic t_incr();
        run_ok("R3 incr word",      32'h100,  3, 2, 1, 0);
        run_ok("R5 incr byte",      32'h201,  4, 0, 1, 0);
        run_ok("R3 incr unaligned", 32'h1003, 2, 2, 1, 0);
        run_ok("R3 incr half unal", 32'h305,  2, 1, 1, 1);
    endtask

    task automatic t_fixed();
        run_ok("R2 fixed half bp",  32'h40, 3, 1, 0, 1);
        run_ok("R2 fixed byte",     32'h43, 15, 0, 0, 0);
    endtask

    task automatic t_wrap();
        run_ok("R4 wrap word bp",   32'h38, 3, 2, 2, 1);
        run_ok("R4 wrap half",      32'h6,  3, 1, 2, 0);
        run_ok("R4 wrap 16 bytes",  32'h1B, 15, 0, 2, 0);
    endtask

    task automatic t_long();
        run_ok("R1 incr 256 beats", 32'h0, 255, 0, 1, 0);
        run_ok("R9 ends at page",   32'hFF8, 1, 2, 1, 0);
    endtask

    task automatic t_errors();
        run_bad("R6 wrap unaligned",  32'h3A,  3, 2, 2);
        run_bad("R6 wrap 3 beats",    32'h30,  2, 2, 2);
        run_bad("R7 fixed 17 beats",  32'h40, 16, 0, 0);
        run_bad("R7 wrap 32 beats",   32'h0,  31, 0, 2);
        run_bad("R8 size too wide",   32'h0,   0, 3, 1);
        run_bad("R9 page crossing",   32'hFF8, 2, 2, 1);
        run_bad("R10 reserved kind",  32'h0,   0, 0, 3);
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_incr();
        t_fixed();
        t_wrap();
        t_errors();
        t_long();
        run_ok("R12 after errors", 32'h500, 1, 2, 1, 0);
        report();
    end

endmodule